// File: doc/BRIEF.md
# UART Interrupt Qualifier with Address Detect

This block merges four UART status conditions into one interrupt request line. There are two transmitter conditions: the transmit buffer is empty, and the transmission is complete. Each has its own mask bit. There are two receiver conditions: data is available, and an overrun occurred. These two share one mask bit. The merged request reaches the output only when a UART-level enable and a chip-wide global enable are both set.

The block also supports a multiprocessor address-detect mode. In this mode, a data-available condition counts only when the most significant bit of the received word is 1, which marks the word as an address. The position of that bit follows the word-length mode: bit index 8 for 9-bit words and bit index 7 for 8-bit words. Address detect and parity cannot be active together. The block forces the effective parity enable low while address detect is on.

The status inputs are levels that the UART holds until its own actions clear them. The request is registered and stays high for as long as a qualified, enabled condition remains.

Top module: `uart_irq_qualifier`

## Requirements
- R1: With `tx_empty_i` high and `tx_empty_en_i` high, `irq_o` rises one clock later. With `tx_empty_en_i` low, that condition has no effect.
- R2: `tx_done_i` is masked only by its own enable, `tx_done_en_i`. The enable of the other transmitter condition neither unmasks it nor masks it.
- R3: `rx_avail_i` and `rx_overrun_i` are both masked by the single enable `rx_en_i`. An overrun raises the request in either address mode.
- R4: With `addr_mode_i` = 0, every data-available condition raises the request, whatever the value of the received word.
- R5: With `addr_mode_i` = 1, data-available raises the request only when the top word bit is 1. The top bit is `rx_word_i[8]` when `wide_mode_i` = 1 and `rx_word_i[7]` when `wide_mode_i` = 0.
- R6: `parity_on_o` equals `parity_req_i` while `addr_mode_i` = 0, and is 0 while `addr_mode_i` = 1.
- R7: `irq_o` is raised only when both `uart_en_i` and `global_en_i` were high in the previous cycle.
- R8: `irq_o` is registered. It stays high while a qualified condition persists, and falls on the first clock edge after the conditions clear.
- R9: While `rst_n` is low, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_empty_i | input | 1 | Transmit buffer empty status |
| tx_done_i | input | 1 | Transmission complete status |
| rx_avail_i | input | 1 | Received data available status |
| rx_overrun_i | input | 1 | Receiver overrun status |
| rx_word_i | input | DATA_W+1 | Last received word |
| wide_mode_i | input | 1 | 1 = 9-bit words, 0 = 8-bit words |
| addr_mode_i | input | 1 | Address-detect mode enable |
| parity_req_i | input | 1 | Requested parity enable |
| tx_empty_en_i | input | 1 | Mask for buffer-empty condition |
| tx_done_en_i | input | 1 | Mask for transmit-complete condition |
| rx_en_i | input | 1 | Shared mask for both receiver conditions |
| uart_en_i | input | 1 | UART-level interrupt enable |
| global_en_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt request |
| parity_on_o | output | 1 | Effective parity enable |

## Verification
The assertions assume that every input is a steady level, sampled at the clock edge. They also assume that the status inputs are driven to known values from time zero, because the gating checks compare `irq_o` with enable values from the previous cycle. The stimulus meets these assumptions by changing inputs only on the falling edge and holding each vector for a full cycle. It also drives the parity request only through the effective-parity output, so the address-mode exclusion can be observed at a port.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Index of the qualifying (top) bit for a given word-length mode.
  function automatic int top_index(input logic wide, input int data_w);
    return wide ? data_w : data_w - 1;
  endfunction

  // Value of the qualifying bit of a received word.
  function automatic logic top_bit(input logic [15:0] word, input logic wide,
                                   input int data_w);
    return word[top_index(wide, data_w)];
  endfunction

  // Effective parity: suppressed while address detect is active.
  function automatic logic eff_parity(input logic req, input logic addr_mode);
    return req & ~addr_mode;
  endfunction

endpackage

// File: rtl/uirq_tx_cond.sv
module uirq_tx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic done_i,
  input  logic empty_en_i,
  input  logic done_en_i,
  output logic tx_req_o
);
  logic empty_hit;
  logic done_hit;

  assign empty_hit = empty_i & empty_en_i;
  assign done_hit  = done_i  & done_en_i;
  assign tx_req_o  = empty_hit | done_hit;

  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_en_i && !done_en_i) |-> !tx_req_o); // R1
  AST_TX_DONE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_i && done_i && done_en_i) |-> tx_req_o); // R2
endmodule

// File: rtl/uirq_rx_qual.sv
module uirq_rx_qual #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              avail_i,
  input  logic              overrun_i,
  input  logic [DATA_W:0]   word_i,
  input  logic              wide_i,
  input  logic              addr_mode_i,
  input  logic              rx_en_i,
  output logic              data_hit_o,
  output logic              rx_req_o
);
  import uirq_pkg::*;

  localparam int WORD_W = DATA_W + 1;

  logic msb;
  logic addr_word;
  logic data_qual;

  assign msb        = top_bit(16'(word_i), wide_i, DATA_W);
  assign addr_word  = addr_mode_i & msb;
  assign data_qual  = ~addr_mode_i | addr_word;
  assign data_hit_o = avail_i & data_qual;
  assign rx_req_o   = rx_en_i & (data_hit_o | overrun_i);

  initial begin
    if (WORD_W > 16) $error("word width exceeds qualifier range");
  end

  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode_i && !msb) |-> !data_hit_o); // R5
  AST_NOADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mode_i && avail_i) |-> data_hit_o); // R4
  AST_RX_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && overrun_i) |-> rx_req_o); // R3
endmodule

// File: rtl/uirq_merge.sv
module uirq_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req_i,
  input  logic rx_req_i,
  input  logic uart_en_i,
  input  logic global_en_i,
  output logic irq_o
);
  logic any_src;
  logic gate_ok;
  logic irq_nxt;

  assign any_src = tx_req_i | rx_req_i;
  assign gate_ok = uart_en_i & global_en_i;
  assign irq_nxt = any_src & gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_nxt;
  end

  AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(uart_en_i && global_en_i)); // R7
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_src) |-> !irq_o); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !irq_o); // R9
endmodule

// File: rtl/uart_irq_qualifier.sv
module uart_irq_qualifier #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_empty_i,
  input  logic            tx_done_i,
  input  logic            rx_avail_i,
  input  logic            rx_overrun_i,
  input  logic [DATA_W:0] rx_word_i,
  input  logic            wide_mode_i,
  input  logic            addr_mode_i,
  input  logic            parity_req_i,
  input  logic            tx_empty_en_i,
  input  logic            tx_done_en_i,
  input  logic            rx_en_i,
  input  logic            uart_en_i,
  input  logic            global_en_i,
  output logic            irq_o,
  output logic            parity_on_o
);
  import uirq_pkg::*;

  logic tx_req;
  logic rx_req;
  logic data_hit;

  uirq_tx_cond u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .empty_i    (tx_empty_i),
    .done_i     (tx_done_i),
    .empty_en_i (tx_empty_en_i),
    .done_en_i  (tx_done_en_i),
    .tx_req_o   (tx_req)
  );

  uirq_rx_qual #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .avail_i     (rx_avail_i),
    .overrun_i   (rx_overrun_i),
    .word_i      (rx_word_i),
    .wide_i      (wide_mode_i),
    .addr_mode_i (addr_mode_i),
    .rx_en_i     (rx_en_i),
    .data_hit_o  (data_hit),
    .rx_req_o    (rx_req)
  );

  uirq_merge u_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_req_i    (tx_req),
    .rx_req_i    (rx_req),
    .uart_en_i   (uart_en_i),
    .global_en_i (global_en_i),
    .irq_o       (irq_o)
  );

  assign parity_on_o = eff_parity(parity_req_i, addr_mode_i);

  AST_PARITY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_mode_i |-> !parity_on_o); // R6
  AST_DATA_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> rx_avail_i); // R4
endmodule

// File: tb/uart_irq_qualifier_test.sv
module uart_irq_qualifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txe = 0, txd = 0, rxa = 0, rxo = 0;
  logic [8:0] word = '0;
  logic wide = 0, addr = 0, preq = 0;
  logic ie_txe = 0, ie_txd = 0, ie_rx = 0, uen = 0, gen = 0;
  logic irq, par;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_qualifier uut (
    .clk(clk), .rst_n(rst_n),
    .tx_empty_i(txe), .tx_done_i(txd), .rx_avail_i(rxa), .rx_overrun_i(rxo),
    .rx_word_i(word), .wide_mode_i(wide), .addr_mode_i(addr),
    .parity_req_i(preq), .tx_empty_en_i(ie_txe), .tx_done_en_i(ie_txd),
    .rx_en_i(ie_rx), .uart_en_i(uen), .global_en_i(gen),
    .irq_o(irq), .parity_on_o(par)
  );

  // Fields: flags{txe,txd,rxa,rxo}[20:17] word[16:8] {wide,addr}[7:6]
  //         enables{txe,txd,rx}[5:3] {uart,global}[2:1] expected irq[0]
  localparam int NV = 16;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {4'b1000, 9'h000, 2'b00, 3'b100, 2'b11, 1'b1}, // R1 enabled
    {4'b1000, 9'h000, 2'b00, 3'b011, 2'b11, 1'b0}, // R1 masked
    {4'b0100, 9'h000, 2'b00, 3'b010, 2'b11, 1'b1}, // R2 own enable
    {4'b0100, 9'h000, 2'b00, 3'b101, 2'b11, 1'b0}, // R2 other enables
    {4'b0010, 9'h000, 2'b00, 3'b001, 2'b11, 1'b1}, // R3 avail
    {4'b0001, 9'h000, 2'b00, 3'b001, 2'b11, 1'b1}, // R3 overrun
    {4'b0011, 9'h000, 2'b00, 3'b110, 2'b11, 1'b0}, // R3 shared mask off
    {4'b0010, 9'h0FF, 2'b00, 3'b001, 2'b11, 1'b1}, // R4 any word
    {4'b0010, 9'h080, 2'b01, 3'b001, 2'b11, 1'b1}, // R5 8-bit, bit7 set
    {4'b0010, 9'h07F, 2'b01, 3'b001, 2'b11, 1'b0}, // R5 8-bit, bit7 clear
    {4'b0010, 9'h080, 2'b11, 3'b001, 2'b11, 1'b0}, // R5 9-bit, bit8 clear
    {4'b0010, 9'h100, 2'b11, 3'b001, 2'b11, 1'b1}, // R5 9-bit, bit8 set
    {4'b0010, 9'h100, 2'b01, 3'b001, 2'b11, 1'b0}, // R5 8-bit ignores bit8
    {4'b0001, 9'h000, 2'b01, 3'b001, 2'b11, 1'b1}, // R3 overrun in addr mode
    {4'b1000, 9'h000, 2'b00, 3'b100, 2'b10, 1'b0}, // R7 global off
    {4'b1000, 9'h000, 2'b00, 3'b100, 2'b01, 1'b0}  // R7 uart off
  };
  localparam int VREQ [0:NV-1] = '{1,1,2,2,3,3,3,4,5,5,5,5,5,3,7,7};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [20:0] v);
    {txe, txd, rxa, rxo} = v[20:17];
    word = v[16:8];
    {wide, addr} = v[7:6];
    {ie_txe, ie_txd, ie_rx} = v[5:3];
    {uen, gen} = v[2:1];
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: all sources live during reset, request must stay low
    drive({4'b1111, 9'h1FF, 2'b00, 3'b111, 2'b11, 1'b0});
    repeat (3) @(negedge clk);
    check("R9", irq, 1'b0);
    drive('0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VREQ[i], i), irq, VEC[i][0]);
    end

    // R8: hold, then release
    drive({4'b1000, 9'h000, 2'b00, 3'b100, 2'b11, 1'b0});
    repeat (3) @(negedge clk);
    check("R8 held", irq, 1'b1);
    txe = 0;
    #1;
    check("R8 before edge", irq, 1'b1);
    @(negedge clk);
    check("R8 cleared", irq, 1'b0);

    // R6: parity exclusion
    preq = 1; addr = 0; #1;
    check("R6 addr off", par, 1'b1);
    addr = 1; #1;
    check("R6 addr on", par, 1'b0);
    preq = 0; addr = 0; #1;
    check("R6 no request", par, 1'b0);

    // R9: asynchronous reset drops an active request
    drive({4'b0100, 9'h000, 2'b00, 3'b010, 2'b11, 1'b0});
    @(negedge clk);
    check("R2 before reset", irq, 1'b1);
    rst_n = 0; #1;
    check("R9 async", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule